// File: doc/BRIEF.md
# Two-Queue Conversion Command Sequencer

This block steps an external analog-to-digital converter through a table of conversion commands. The table has 64 entries. Each entry names one input channel and may carry a pause mark and an end mark. The table is shared by two queues. Queue 1 runs from entry 0 up to the entry just below a configurable split index. Queue 2 runs from the split index upward. Each queue has its own trigger pulse, its own read pointer, an encoded status and a sticky overrun flag.

For every command, the block sends a one-cycle request with the channel number and waits for the converter's done pulse. It then stores the returned value in a 64-entry result table at the index of that command. Queue 1 always wins. If queue 2 is triggered while queue 1 is running, queue 2 waits. If queue 1 is triggered while queue 2 is running, queue 1 takes over as soon as the conversion in flight has finished, and queue 2 resumes later from where it stopped. A pause mark stops a queue after that entry until its next trigger. This gives several subqueues inside one queue.

The table is loaded through a simple write port and the results are read through a combinational read port.

Top module: `conv_seq`

## Requirements
- R1: After reset both statuses read 00, both overrun flags are 0 and conv_req is 0.
- R2: Status encoding is 00 idle, 01 active, 10 paused, 11 waiting (pending). A trigger on an idle queue starts it at its first entry: entry 0 for queue 1, entry q2_base for queue 2.
- R3: Each command is issued as a conv_req pulse exactly one cycle long, with conv_chan holding that entry's channel. No new request is issued until conv_done has returned for the previous one.
- R4: The result returned with conv_done is written at the index of the command that produced it. A conv_done pulse with no conversion outstanding writes nothing.
- R5: Queue 1 completes after the entry q2_base-1, or after an entry with the end mark. Queue 2 completes after entry 63, or after an entry with the end mark. On completion the queue becomes idle.
- R6: After converting an entry with the pause mark (and no end mark), a queue reads 10. Its next trigger resumes it at the following entry.
- R7: A queue 2 trigger while queue 1 is active sets queue 2 to 11. Queue 2 becomes active in the cycle queue 1 completes or pauses.
- R8: A queue 1 trigger while queue 2 is active makes queue 1 active and queue 2 read 11. The conversion in flight still finishes and its result is stored. Queue 2 later resumes at its next entry. Queue 1 never reads 11, and the two queues are never both 01.
- R9: A trigger on an active queue, or on queue 2 while it reads 11, sets that queue's sticky overrun flag and does not restart the queue.
- R10: Writing 1 to ovr_clr bit 0 clears the queue 1 flag, and writing 1 to bit 1 clears the queue 2 flag. A new overrun in the same cycle as a clear wins.
- R11: Triggers for both idle queues in the same cycle make queue 1 active and queue 2 read 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Command table write enable |
| tbl_waddr | input | 6 | Command table write index |
| tbl_wchan | input | CW | Channel of written entry |
| tbl_wpause | input | 1 | Pause mark of written entry |
| tbl_wlast | input | 1 | End mark of written entry |
| q2_base | input | 6 | First entry of queue 2 |
| go1 | input | 1 | Queue 1 trigger pulse |
| go2 | input | 1 | Queue 2 trigger pulse |
| ovr_clr | input | 2 | Write-1 clear of overrun flags (bit 0 queue 1) |
| conv_req | output | 1 | Conversion request pulse |
| conv_chan | output | CW | Channel for the request |
| conv_done | input | 1 | Conversion finished pulse |
| conv_result | input | RW | Converted value |
| res_raddr | input | 6 | Result table read index |
| res_rdata | output | RW | Result table read data |
| q1_state | output | 2 | Queue 1 status |
| q2_state | output | 2 | Queue 2 status |
| q1_ovr | output | 1 | Queue 1 overrun flag |
| q2_ovr | output | 1 | Queue 2 overrun flag |

## Verification
Each queue is run alone through a pause and then to completion. This separates the pause stop from the end-of-range stop at q2_base-1 and from the end mark. A queue 2 trigger during a queue 1 run, and a queue 1 trigger during a queue 2 run, exercise waiting and takeover. These patterns also tell a correct resume pointer apart from a restart at the base. Repeated triggers, simultaneous triggers, clear-versus-set collisions and a stray done pulse cover overrun, the priority tie and the ignore rule. All outputs are compared every cycle against a behavioural model.

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int N  = 64,
  parameter int CW = 4,
  parameter int RW = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tbl_we,
  input  logic [$clog2(N)-1:0] tbl_waddr,
  input  logic [CW-1:0]        tbl_wchan,
  input  logic                 tbl_wpause,
  input  logic                 tbl_wlast,
  input  logic [$clog2(N)-1:0] q2_base,
  input  logic                 go1,
  input  logic                 go2,
  input  logic [1:0]           ovr_clr,
  output logic                 conv_req,
  output logic [CW-1:0]        conv_chan,
  input  logic                 conv_done,
  input  logic [RW-1:0]        conv_result,
  input  logic [$clog2(N)-1:0] res_raddr,
  output logic [RW-1:0]        res_rdata,
  output logic [1:0]           q1_state,
  output logic [1:0]           q2_state,
  output logic                 q1_ovr,
  output logic                 q2_ovr
);
  localparam int AW = $clog2(N);
  localparam logic [1:0] IDLE = 2'b00, ACT = 2'b01, PAUS = 2'b10, PEND = 2'b11;

  logic [CW-1:0] chan_m [N];
  logic          pau_m  [N];
  logic          lst_m  [N];
  logic [RW-1:0] res_m  [N];

  logic [1:0]    s1, s2, s1n, s2n;
  logic [AW-1:0] p1, p2, p1n, p2n, cur;
  logic          busy, own;

  wire           fin      = conv_done & busy;
  wire [AW-1:0]  q1_end   = q2_base - 1'b1;
  wire [AW-1:0]  nxt      = cur + 1'b1;
  wire           cur_last = lst_m[cur] | (own ? (&cur) : (cur == q1_end));
  wire           cur_pau  = pau_m[cur];
  wire           issue    = !busy && (s1 == ACT || s2 == ACT);
  wire           use2     = (s1 != ACT);
  wire [AW-1:0]  ip       = use2 ? p2 : p1;
  wire           ov1_set  = go1 && (s1 == ACT);
  wire           ov2_set  = go2 && (s2 == ACT || s2 == PEND);

  always_comb begin
    s1n = s1;
    s2n = s2;
    p1n = p1;
    p2n = p2;
    if (fin) begin
      if (!own) begin
        p1n = nxt;
        if (cur_last)     s1n = IDLE;
        else if (cur_pau) s1n = PAUS;
      end else begin
        p2n = nxt;
        if (cur_last)     s2n = IDLE;
        else if (cur_pau) s2n = PAUS;
      end
    end
    if (go1) begin
      if (s1 == IDLE) begin
        s1n = ACT;
        p1n = '0;
      end else if (s1 == PAUS) begin
        s1n = ACT;
      end
    end
    if (go2) begin
      if (s2 == IDLE) begin
        s2n = PEND;
        p2n = q2_base;
      end else if (s2 == PAUS) begin
        s2n = PEND;
      end
    end
    if (s1n == ACT && s2n == ACT)      s2n = PEND;
    else if (s1n != ACT && s2n == PEND) s2n = ACT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1        <= IDLE;
      s2        <= IDLE;
      p1        <= '0;
      p2        <= '0;
      cur       <= '0;
      busy      <= 1'b0;
      own       <= 1'b0;
      conv_req  <= 1'b0;
      conv_chan <= '0;
      q1_ovr    <= 1'b0;
      q2_ovr    <= 1'b0;
    end else begin
      s1       <= s1n;
      s2       <= s2n;
      p1       <= p1n;
      p2       <= p2n;
      conv_req <= issue;
      q1_ovr   <= ov1_set | (q1_ovr & ~ovr_clr[0]);
      q2_ovr   <= ov2_set | (q2_ovr & ~ovr_clr[1]);
      if (issue) begin
        busy      <= 1'b1;
        own       <= use2;
        cur       <= ip;
        conv_chan <= chan_m[ip];
      end else if (fin) begin
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tbl_we) begin
      chan_m[tbl_waddr] <= tbl_wchan;
      pau_m[tbl_waddr]  <= tbl_wpause;
      lst_m[tbl_waddr]  <= tbl_wlast;
    end
    if (fin) res_m[cur] <= conv_result;
  end

  assign res_rdata = res_m[res_raddr];
  assign q1_state  = s1;
  assign q2_state  = s2;
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go1,
  input logic       go2,
  input logic [1:0] ovr_clr,
  input logic       conv_req,
  input logic       conv_done,
  input logic [1:0] q1_state,
  input logic [1:0] q2_state,
  input logic       q1_ovr,
  input logic       q2_ovr
);
  logic wait_c;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wait_c <= 1'b0;
    else if (conv_req)  wait_c <= 1'b1;
    else if (conv_done) wait_c <= 1'b0;
  end

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) conv_req |=> !conv_req); // R3
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) conv_req |-> !wait_c); // R3
  AST_GO1_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (go1 && q1_state != 2'b01) |=> q1_state == 2'b01); // R2
  AST_PEND_BEHIND_Q1: assert property (@(posedge clk) disable iff (!rst_n) q2_state == 2'b11 |-> q1_state == 2'b01); // R7
  AST_Q1_NEVER_WAITS: assert property (@(posedge clk) disable iff (!rst_n) q1_state != 2'b11); // R8
  AST_NOT_BOTH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) !(q1_state == 2'b01 && q2_state == 2'b01)); // R8
  AST_OVR2_SET: assert property (@(posedge clk) disable iff (!rst_n) (go2 && (q2_state == 2'b01 || q2_state == 2'b11)) |=> q2_ovr); // R9
  AST_OVR1_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (q1_ovr && !ovr_clr[0]) |=> q1_ovr); // R10
  AST_OVR2_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (q2_ovr && !ovr_clr[1]) |=> q2_ovr); // R10
endmodule

bind conv_seq conv_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go1(go1), .go2(go2), .ovr_clr(ovr_clr),
  .conv_req(conv_req), .conv_done(conv_done), .q1_state(q1_state),
  .q2_state(q2_state), .q1_ovr(q1_ovr), .q2_ovr(q2_ovr)
);

// File: tb/conv_seq_bench.sv
module conv_seq_bench;
  localparam int N = 64, CW = 4, RW = 10;

  logic clk = 0, rst_n = 0;
  logic tbl_we = 0, tbl_wpause = 0, tbl_wlast = 0;
  logic [5:0] tbl_waddr = 0, q2_base = 6'd8, res_raddr = 0;
  logic [CW-1:0] tbl_wchan = 0;
  logic go1 = 0, go2 = 0, conv_done = 0;
  logic [1:0] ovr_clr = 0;
  logic [RW-1:0] conv_result = 0;
  logic conv_req, q1_ovr, q2_ovr;
  logic [CW-1:0] conv_chan;
  logic [RW-1:0] res_rdata;
  logic [1:0] q1_state, q2_state;

  always #2 clk = ~clk;

  conv_seq #(.N(N), .CW(CW), .RW(RW)) u_conv_seq (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_wchan(tbl_wchan), .tbl_wpause(tbl_wpause), .tbl_wlast(tbl_wlast),
    .q2_base(q2_base), .go1(go1), .go2(go2), .ovr_clr(ovr_clr),
    .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_result(conv_result), .res_raddr(res_raddr), .res_rdata(res_rdata),
    .q1_state(q1_state), .q2_state(q2_state), .q1_ovr(q1_ovr), .q2_ovr(q2_ovr)
  );

  int total = 0, bad = 0;
  string ph = "R1";

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model
  int mch[N], mpa[N], mla[N], mres[N], mwr[N];
  int m1, m2, mp1, mp2, mo1, mo2, mbusy, mowner, midx, mreq, mchan;

  always @(posedge clk) begin
    if (!rst_n) begin
      m1 = 0; m2 = 0; mp1 = 0; mp2 = 0; mo1 = 0; mo2 = 0;
      mbusy = 0; mowner = 0; midx = 0; mreq = 0; mchan = 0;
    end else begin
      int o1, o2, last, lim, start_now, take;
      bit done_now;
      o1 = m1; o2 = m2;
      done_now = conv_done && mbusy != 0;
      take = (mbusy == 0) && (o1 == 1 || o2 == 1);
      if (go1 && o1 == 1) mo1 = 1; else if (ovr_clr[0]) mo1 = 0;
      if (go2 && (o2 == 1 || o2 == 3)) mo2 = 1; else if (ovr_clr[1]) mo2 = 0;
      if (done_now) begin
        mres[midx] = conv_result; mwr[midx] = 1;
        lim = (mowner == 0) ? (q2_base + 63) % 64 : 63;
        last = mla[midx] != 0 || midx == lim;
        if (mowner == 0) begin
          mp1 = (midx + 1) % 64;
          if (last) m1 = 0; else if (mpa[midx] != 0) m1 = 2;
        end else begin
          mp2 = (midx + 1) % 64;
          if (last) m2 = 0; else if (mpa[midx] != 0) m2 = 2;
        end
        mbusy = 0;
      end
      if (go1 && (o1 == 0 || o1 == 2)) begin
        if (o1 == 0) mp1 = 0;
        m1 = 1;
      end
      start_now = go2 && (o2 == 0 || o2 == 2);
      if (start_now) begin
        if (o2 == 0) mp2 = q2_base;
        m2 = 3;
      end
      if (m2 == 1 && m1 == 1) m2 = 3;
      if (m2 == 3 && m1 != 1) m2 = 1;
      mreq = take;
      if (take) begin
        mowner = (o1 == 1) ? 0 : 1;
        midx = (o1 == 1) ? mp1 : mp2;
        mchan = mch[midx];
        mbusy = 1;
      end
    end
  end

  // converter emulation
  int lat = 2, cnt = 0, rc = 0, seq = 0;
  bit stray = 0;
  initial forever @(negedge clk) begin
    conv_done = 0;
    if (stray) begin
      conv_done = 1; conv_result = 10'd999; stray = 0;
    end else if (conv_req) begin
      cnt = lat; rc = conv_chan;
    end else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        conv_done = 1; conv_result = RW'((rc * 37 + seq * 11) % 1024); seq++;
      end
    end
  end

  // per-cycle comparison
  initial forever @(negedge clk) begin
    if (rst_n) begin
      chk(q1_state, m1, {ph, " q1_state"});
      chk(q2_state, m2, {ph, " q2_state"});
      chk(q1_ovr, mo1, {ph, " q1_ovr"});
      chk(q2_ovr, mo2, {ph, " q2_ovr"});
      chk(conv_req, mreq, {ph, " conv_req"});
      if (mreq != 0) chk(conv_chan, mchan, {ph, " conv_chan"});
    end
  end

  task automatic put(input int i, input int ch, input int pa, input int la);
    @(negedge clk);
    tbl_we = 1; tbl_waddr = 6'(i); tbl_wchan = CW'(ch); tbl_wpause = pa[0]; tbl_wlast = la[0];
    mch[i] = ch; mpa[i] = pa; mla[i] = la;
  endtask

  task automatic pulse(input bit a, input bit b);
    @(negedge clk); go1 = a; go2 = b;
    @(negedge clk); go1 = 0; go2 = 0;
  endtask

  task automatic settle;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (q1_state != 2'b01 && q2_state != 2'b01 && q2_state != 2'b11 && cnt == 0 && !conv_req) break;
    end
  endtask

  task automatic wait_req;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (conv_req) break;
    end
  endtask

  initial begin
    int keep;
    repeat (3) @(negedge clk);
    chk(q1_state, 0, "R1 q1 reset"); chk(q2_state, 0, "R1 q2 reset");
    chk(q1_ovr, 0, "R1 ovr1 reset"); chk(conv_req, 0, "R1 req reset");
    rst_n = 1;
    for (int i = 0; i < N; i++) put(i, (i * 5 + 3) % 16, (i == 2 || i == 10) ? 1 : 0, (i == 13) ? 1 : 0);
    @(negedge clk); tbl_we = 0;

    ph = "R2";
    pulse(1, 0);
    chk(q1_state, 1, "R2 q1 active");
    wait_req(); chk(conv_chan, mch[0], "R2 q1 first entry 0");
    ph = "R6"; settle();
    chk(q1_state, 2, "R6 q1 paused after entry 2");
    pulse(1, 0); wait_req(); chk(conv_chan, mch[3], "R6 resume at entry 3");
    ph = "R5"; settle();
    chk(q1_state, 0, "R5 q1 idle after q2_base-1");

    ph = "R2"; pulse(0, 1); wait_req(); chk(conv_chan, mch[8], "R2 q2 first entry q2_base");
    settle(); chk(q2_state, 2, "R6 q2 paused at 10");
    ph = "R5"; pulse(0, 1); settle(); chk(q2_state, 0, "R5 q2 idle after end mark");

    ph = "R7"; pulse(1, 0); @(negedge clk);
    pulse(0, 1); chk(q2_state, 3, "R7 q2 waiting");
    ph = "R9"; pulse(0, 1); chk(q2_ovr, 1, "R9 q2 overrun on waiting");
    ph = "R7"; settle();
    chk(q1_state, 2, "R7 q1 paused"); chk(q2_state, 2, "R7 q2 ran after q1");

    ph = "R8"; pulse(0, 1); wait_req();
    pulse(1, 0); chk(q2_state, 3, "R8 q2 displaced");
    ph = "R9"; pulse(1, 0); chk(q1_ovr, 1, "R9 q1 overrun on active");
    ph = "R8"; settle(); chk(q1_state, 0, "R8 q1 finished"); chk(q2_state, 0, "R8 q2 finished");
    chk(mwr[11], 1, "R8 in-flight entry 11 stored");

    ph = "R10"; @(negedge clk); ovr_clr = 2'b01; @(negedge clk); ovr_clr = 0;
    chk(q1_ovr, 0, "R10 q1 cleared"); chk(q2_ovr, 1, "R10 q2 kept");

    ph = "R11"; pulse(1, 1); chk(q1_state, 1, "R11 q1 first"); chk(q2_state, 3, "R11 q2 waits");
    wait_req(); wait_req();
    ph = "R10"; @(negedge clk); go2 = 1; ovr_clr = 2'b10; @(negedge clk); go2 = 0; ovr_clr = 0;
    chk(q2_ovr, 1, "R10 set wins over clear");
    @(negedge clk); ovr_clr = 2'b10; @(negedge clk); ovr_clr = 0;
    chk(q2_ovr, 0, "R10 q2 cleared");
    ph = "R11"; settle();

    ph = "R4"; keep = mres[midx];
    @(negedge clk); stray = 1; repeat (3) @(negedge clk);
    res_raddr = 6'(midx); #1;
    chk(res_rdata, keep, "R4 stray done ignored");
    for (int i = 0; i < N; i++) begin
      if (mwr[i] != 0) begin
        @(negedge clk); res_raddr = 6'(i); #1;
        chk(res_rdata, mres[i], "R4 result at command index");
      end
    end
    chk(conv_req, 0, "R3 no request when idle");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule